// File: doc/BRIEF.md
# Keyed-Reload Watchdog Timer

This block is a memory-mapped watchdog. Software enables it and picks a timeout code, and must then restart the countdown again and again by writing a fixed key to a control address. A divider turns the input clock into half-second ticks. Each 4-bit timeout code maps to a tick count through a fixed nonlinear table that runs from 0.5 s to 16 s. If the count runs out, the block does one of two things, chosen by a configuration field: it drives a system-reset pulse of fixed length and disables itself, or it raises an interrupt that stays set.

Register access is a simple synchronous port with an address, write data and a write strobe, plus a combinational read-data output. A parameter chooses between two register layouts. The full layout places control, configuration and mode at three separate addresses. The compact layout places control at one address and puts configuration and mode into a single shared word.

Top module: `wdog_keyed`

## Requirements
- R1: A write to the control address reloads the countdown from the stored timeout code and restarts the tick divider, so that expiry follows exactly ticks(code) x TICK_CYCLES clock edges after that write. This happens only when bit 0 of the written word is 1 and bits [12:1] equal 0xA57 (the full word 0x14AF).
- R2: Any other value written to the control address is ignored, and the pending expiry time does not change.
- R3: Bit 0 of the mode word is the enable. Writing 0 to that bit stops the countdown, and no expiry action follows while the block is disabled.
- R4: The timeout code maps to half-second ticks as follows: code 0 gives 1; codes 1 to 6 give 2 x code; codes 7 to 11 give 16, 20, 24, 28 and 32 in turn; codes 12 to 15 give 32.
- R5: In the full layout, control is at 0x10, configuration at 0x14 and mode at 0x18. The mode word holds the enable at bit 0 and the code at bits [7:4]. The configuration word holds a 2-bit action at bits [1:0], and the value 01 selects reset.
- R6: In the compact layout, control is at 0x00 and a single word at 0x04 holds the enable at bit 0, the reset select at bit 1 and the code at bits [6:3].
- R7: A 0-to-1 change of the enable loads the countdown from the code written with it. A code written while the block is already enabled takes effect only at the next valid keyed reload.
- R8: On expiry with the reset action selected, sys_rst_o is high for exactly RST_PULSE_CYCLES cycles, the stored enable clears, and irq_o stays low.
- R9: On expiry with any other action value, irq_o goes high and stays high until a valid keyed reload clears it.
- R10: Reads return only the stored fields, with all other bits zero. Reads of the control address and of unmapped addresses return zero.
- R11: After reset the block is disabled, the code and action are 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle it is high |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| sys_rst_o | output | 1 | System-reset pulse on expiry |
| irq_o | output | 1 | Sticky expiry interrupt |

## Verification
A wrong timeout decode or a wrong divider count shows up as an expiry that comes early or late by a whole number of TICK_CYCLES. The bench measures this to the exact clock edge, for every code in both layouts. If a bad key reloads the counter, or a code written while running reloads it, the expiry edge moves by a known number of cycles on the next countdown. A wrong stored enable or action shows up directly in the read value of the mode or configuration word. The shape of the reset pulse and the stickiness of the interrupt are visible at the output pins within the first few cycles after expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned CODE_W    = 4;
    localparam int unsigned ACT_W     = 2;
    localparam int unsigned MAX_TICKS = 32;
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [11:0] RELOAD_KEY = 12'hA57;
    localparam logic [ACT_W-1:0] ACT_RESET = 2'b01;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic [ACT_W-1:0]  act;
        logic [CNT_W-1:0]  cnt;
        logic              irq;
    } wdog_state_t;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int unsigned TICK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = run && !clr && (pre_q == LAST);
        pre_d = pre_q;
        if (clr || !run || (pre_q == LAST)) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
    parameter int unsigned PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    localparam int unsigned RW = $clog2(PULSE_CYCLES + 1);

    logic [RW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (fire)               left_d = RW'(PULSE_CYCLES);
        else if (left_q != '0)  left_d = left_q - RW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign pulse = (left_q != '0);
endmodule

// File: rtl/wdog_timeout_decode.sv
module wdog_timeout_decode
    import wdog_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  ticks
);
    always_comb begin
        unique case (code)
            4'h0:    ticks = CNT_W'(1);
            4'h1:    ticks = CNT_W'(2);
            4'h2:    ticks = CNT_W'(4);
            4'h3:    ticks = CNT_W'(6);
            4'h4:    ticks = CNT_W'(8);
            4'h5:    ticks = CNT_W'(10);
            4'h6:    ticks = CNT_W'(12);
            4'h7:    ticks = CNT_W'(16);
            4'h8:    ticks = CNT_W'(20);
            4'h9:    ticks = CNT_W'(24);
            4'hA:    ticks = CNT_W'(28);
            default: ticks = CNT_W'(MAX_TICKS);
        endcase
    end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter bit          COMPACT          = 1'b0,
    parameter int unsigned TICK_CYCLES      = 62_500_000,
    parameter int unsigned RST_PULSE_CYCLES = 16,
    parameter int unsigned ADDR_W           = 8,
    parameter int unsigned DATA_W           = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sys_rst_o,
    output logic              irq_o
);
    wdog_state_t s_d, s_q;

    logic              wr_ctrl, wr_mode, wr_cfg;
    logic              new_en;
    logic [CODE_W-1:0] new_code;
    logic [ACT_W-1:0]  new_act;
    logic [DATA_W-1:0] rd;
    logic [CNT_W-1:0]  ticks_now, ticks_new;
    logic              key_ok, tick, tick_clr, fire;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:13];

    generate
        if (COMPACT) begin : g_compact
            localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
            localparam logic [ADDR_W-1:0] A_WORD = ADDR_W'(8'h04);
            always_comb begin
                wr_ctrl  = reg_we && (reg_addr == A_CTRL);
                wr_mode  = reg_we && (reg_addr == A_WORD);
                wr_cfg   = wr_mode;
                new_en   = reg_wdata[0];
                new_act  = {1'b0, reg_wdata[1]};
                new_code = reg_wdata[6:3];
                rd       = '0;
                if (reg_addr == A_WORD) begin
                    rd[0]   = s_q.en;
                    rd[1]   = s_q.act[0];
                    rd[6:3] = s_q.code;
                end
            end
        end else begin : g_full
            localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h10);
            localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(8'h14);
            localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h18);
            always_comb begin
                wr_ctrl  = reg_we && (reg_addr == A_CTRL);
                wr_mode  = reg_we && (reg_addr == A_MODE);
                wr_cfg   = reg_we && (reg_addr == A_CFG);
                new_en   = reg_wdata[0];
                new_act  = reg_wdata[1:0];
                new_code = reg_wdata[7:4];
                rd       = '0;
                if (reg_addr == A_CFG) begin
                    rd[1:0] = s_q.act;
                end else if (reg_addr == A_MODE) begin
                    rd[0]   = s_q.en;
                    rd[7:4] = s_q.code;
                end
            end
        end
    endgenerate

    wdog_timeout_decode u_dec_now (.code(s_q.code), .ticks(ticks_now));
    wdog_timeout_decode u_dec_new (.code(new_code), .ticks(ticks_new));

    wdog_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(s_q.en), .clr(tick_clr), .tick(tick)
    );

    wdog_pulse_gen #(.PULSE_CYCLES(RST_PULSE_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(sys_rst_o)
    );

    assign key_ok = wr_ctrl && reg_wdata[0] && (reg_wdata[12:1] == RELOAD_KEY);

    always_comb begin
        s_d      = s_q;
        tick_clr = 1'b0;
        fire     = 1'b0;
        if (wr_cfg) begin
            s_d.act = new_act;
        end
        if (wr_mode) begin
            s_d.en   = new_en;
            s_d.code = new_code;
            if (new_en && !s_q.en) begin
                s_d.cnt  = ticks_new;
                tick_clr = 1'b1;
            end
        end
        if (key_ok) begin
            s_d.cnt  = ticks_now;
            s_d.irq  = 1'b0;
            tick_clr = 1'b1;
        end else if (s_q.en && s_d.en && tick && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
            if (s_q.cnt == CNT_W'(1)) begin
                if (s_q.act == ACT_RESET) begin
                    fire   = 1'b1;
                    s_d.en = 1'b0;
                end else begin
                    s_d.irq = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_rdata = rd;
    assign irq_o     = s_q.irq;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
    parameter bit          COMPACT          = 1'b0,
    parameter int unsigned RST_PULSE_CYCLES = 16,
    parameter int unsigned ADDR_W           = 8,
    parameter int unsigned DATA_W           = 32,
    parameter int unsigned CNT_W            = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              sys_rst_o,
    input logic              irq_o,
    input logic              en_q,
    input logic [CNT_W-1:0]  cnt_q
);
    localparam logic [ADDR_W-1:0] CTRL = COMPACT ? ADDR_W'(8'h00) : ADDR_W'(8'h10);

    logic key_wr;
    assign key_wr = reg_we && (reg_addr == CTRL) && (reg_wdata[12:0] == 13'h14AF);

    logic [31:0] hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_q <= '0;
        else if (sys_rst_o) hi_q <= hi_q + 32'd1;
        else                hi_q <= '0;
    end

    // R8: reset pulse never exceeds its configured length
    p_rst_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_q <= RST_PULSE_CYCLES);

    // R8: a finished reset pulse had the full length
    p_rst_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> (hi_q == RST_PULSE_CYCLES));

    // R8: the block is disabled once the reset pulse starts
    p_rst_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> !en_q);

    // R9: the interrupt holds until a keyed reload
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !key_wr) |=> irq_o);

    // R3: no expiry action while disabled
    p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!$rose(irq_o) && !$rose(sys_rst_o)));

    // R10: control address reads zero
    p_ctrl_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CTRL) |-> (reg_rdata == '0));

    // R4: countdown stays within the longest timeout
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(32));
endmodule

bind wdog_keyed wdog_keyed_chk #(
    .COMPACT(COMPACT),
    .RST_PULSE_CYCLES(RST_PULSE_CYCLES),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W(wdog_pkg::CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .sys_rst_o(sys_rst_o),
    .irq_o(irq_o), .en_q(s_q.en), .cnt_q(s_q.cnt)
);

// File: tb/wdog_keyed_bench.sv
`timescale 1ns/1ps
module wdog_keyed_bench;
    localparam int TICK  = 4;
    localparam int PULSE = 3;
    localparam logic [31:0] KEY = 32'h0000_14AF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic we_d = 1'b0, we_c = 1'b0;
    logic [31:0] rdata_d, rdata_c;
    logic srst_d, irq_d, srst_c, irq_c;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_keyed #(.COMPACT(1'b0), .TICK_CYCLES(TICK), .RST_PULSE_CYCLES(PULSE)) u_wdog_keyed (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we_d),
        .reg_rdata(rdata_d), .sys_rst_o(srst_d), .irq_o(irq_d));

    wdog_keyed #(.COMPACT(1'b1), .TICK_CYCLES(TICK), .RST_PULSE_CYCLES(PULSE)) u_wdog_keyed_cmp (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we_c),
        .reg_rdata(rdata_c), .sys_rst_o(srst_c), .irq_o(irq_c));

    function automatic int exp_ticks(input int code);
        if (code == 0)       return 1;
        else if (code <= 6)  return 2 * code;
        else if (code <= 11) return 2 * (8 + 2 * (code - 7));
        else                 return 32;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // returns with cyc equal to the edge that took the write
    task automatic wr(input bit cmp, input logic [7:0] a, input logic [31:0] d, output int t);
        @(negedge clk);
        addr = a; wdata = d;
        if (cmp) we_c = 1'b1; else we_d = 1'b1;
        @(negedge clk);
        we_c = 1'b0; we_d = 1'b0;
        t = cyc;
    endtask

    task automatic rd(input bit cmp, input logic [7:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1;
        v = cmp ? int'(rdata_c) : int'(rdata_d);
    endtask

    // sel: 0 irq, 1 sys_rst; t = edge count at which it is first seen high, 0 if never
    task automatic wait_sig(input bit cmp, input bit sel, input int limit, output int t);
        t = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            #1;
            if (sel ? (cmp ? srst_c : srst_d) : (cmp ? irq_c : irq_d)) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic clear_full();
        int t;
        wr(1'b0, 8'h18, 32'h0, t);
        wr(1'b0, 8'h10, KEY, t);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int t0, t1, t, v, hi;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(1'b0, 8'h18, v); chk("R11 mode after reset", v, 0);
        rd(1'b0, 8'h14, v); chk("R11 cfg after reset", v, 0);
        chk("R11 irq after reset", int'(irq_d), 0);
        chk("R11 sys_rst after reset", int'(srst_d), 0);
        rd(1'b1, 8'h04, v); chk("R11 compact word after reset", v, 0);

        // R10 / R5 readback of stored fields only
        wr(1'b0, 8'h14, 32'hFFFF_FFFE, t);
        rd(1'b0, 8'h14, v); chk("R10 cfg readback", v, 2);
        wr(1'b0, 8'h18, 32'hFFFF_FFBE, t);
        rd(1'b0, 8'h18, v); chk("R5 mode readback", v, 32'hB0);
        rd(1'b0, 8'h10, v); chk("R10 ctrl reads zero", v, 0);
        rd(1'b0, 8'h20, v); chk("R10 unmapped reads zero", v, 0);
        clear_full();

        // R4 sweep of every code, interrupt action (cfg = 2)
        for (int code = 0; code < 16; code++) begin
            wr(1'b0, 8'h18, 32'(code << 4) | 32'h1, t0);
            wait_sig(1'b0, 1'b0, 200, t);
            chk($sformatf("R4 code %0d expiry cycles", code), t - t0, exp_ticks(code) * TICK);
            repeat (5) @(posedge clk);
            #1;
            chk($sformatf("R9 irq sticky code %0d", code), int'(irq_d), 1);
            clear_full();
            #1;
            chk($sformatf("R9 irq cleared by key code %0d", code), int'(irq_d), 0);
        end

        // R1 keyed reload restarts the full period
        wr(1'b0, 8'h18, 32'h21, t0);
        repeat (9) @(posedge clk);
        wr(1'b0, 8'h10, KEY, t1);
        wait_sig(1'b0, 1'b0, 200, t);
        chk("R1 expiry after keyed reload", t - t1, 4 * TICK);
        clear_full();

        // R2 wrong keys ignored
        wr(1'b0, 8'h18, 32'h21, t0);
        wr(1'b0, 8'h10, 32'h0000_14AE, t1);
        wr(1'b0, 8'h10, 32'h0000_14AD, t1);
        wr(1'b0, 8'h10, 32'h0000_0001, t1);
        wait_sig(1'b0, 1'b0, 200, t);
        chk("R2 bad keys leave expiry unchanged", t - t0, 4 * TICK);
        clear_full();

        // R7 code change while running waits for reload
        wr(1'b0, 8'h18, 32'h11, t0);
        wr(1'b0, 8'h18, 32'h31, t1);
        wait_sig(1'b0, 1'b0, 200, t);
        chk("R7 running code change deferred", t - t0, 2 * TICK);
        rd(1'b0, 8'h18, v); chk("R7 new code stored", v, 32'h31);
        wr(1'b0, 8'h10, KEY, t1);
        wait_sig(1'b0, 1'b0, 200, t);
        chk("R7 new code used at reload", t - t1, 6 * TICK);
        clear_full();

        // R3 disable stops the countdown
        wr(1'b0, 8'h18, 32'h01, t0);
        wr(1'b0, 8'h18, 32'h00, t1);
        wait_sig(1'b0, 1'b0, 40, t);
        chk("R3 no irq after stop", t, 0);
        rd(1'b0, 8'h18, v); chk("R3 mode reads zero after stop", v, 0);

        // R8 reset action
        wr(1'b0, 8'h14, 32'h1, t);
        wr(1'b0, 8'h18, 32'h11, t0);
        wait_sig(1'b0, 1'b1, 200, t);
        chk("R8 reset pulse time", t - t0, 2 * TICK);
        chk("R8 irq low on reset action", int'(irq_d), 0);
        hi = 1;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk);
            #1;
            if (srst_d) hi++;
            else break;
        end
        chk("R8 reset pulse width", hi, PULSE);
        rd(1'b0, 8'h18, v); chk("R8 enable cleared", v, 32'h10);

        // R9 other action value (3) gives interrupt
        wr(1'b0, 8'h14, 32'h3, t);
        wr(1'b0, 8'h18, 32'h01, t0);
        wait_sig(1'b0, 1'b0, 200, t);
        chk("R9 action 3 gives irq", t - t0, TICK);
        chk("R9 no reset pulse on action 3", int'(srst_d), 0);
        clear_full();

        // R6 compact layout
        wr(1'b1, 8'h04, 32'h39, t0);
        wait_sig(1'b1, 1'b0, 300, t);
        chk("R6 compact code 7 expiry", t - t0, 16 * TICK);
        rd(1'b1, 8'h04, v); chk("R6 compact readback", v, 32'h39);
        rd(1'b1, 8'h00, v); chk("R10 compact ctrl reads zero", v, 0);
        wr(1'b1, 8'h00, KEY, t1);
        #1;
        chk("R6 compact key clears irq", int'(irq_c), 0);
        wr(1'b1, 8'h04, 32'h0, t);
        wr(1'b1, 8'h04, 32'h3, t0);
        wait_sig(1'b1, 1'b1, 100, t);
        chk("R6 compact reset select", t - t0, TICK);
        rd(1'b1, 8'h04, v); chk("R6 compact enable cleared", v, 2);
        chk("R6 default instance untouched", int'(irq_d | srst_d), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule